// File: doc/BRIEF.md
# Iterative 32-by-16 Divider with Legacy Cycle Timing

This block divides a 32-bit dividend by a 16-bit divisor, either as unsigned numbers or as two's-complement signed numbers. It returns a 16-bit quotient, a 16-bit remainder, a divide-by-zero flag, an overflow flag and a cycle count. The cycle count reproduces the data-dependent timing of an older microcoded divide instruction for a register operand. Operand fetch time is not included.

The result is not only reported. The block also takes exactly that many clock cycles, so a surrounding pipeline sees the original timing. A shift-subtract engine finds the quotient and the unsigned step count in 16 clock cycles. A latency timer holds the result until the reported count has elapsed.

Requests enter through a valid/ready handshake. `in_ready` is high whenever the block is idle. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low until the result is delivered. While it is low, `in_valid` and the operand pins are ignored, so the producer is back-pressured and must hold its next request. The result side has no back-pressure. `out_valid` is a one-cycle pulse, and the consumer must capture the result in that cycle. The result registers and flags keep their last values between pulses.

Top module: `sdiv_legacy_timed`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, and the quotient, remainder, flags and cycle count are all 0.
- R2: If a request is taken on rising edge k, `out_valid` is high for exactly the one cycle that follows edge k+N. N is the reported `out_cycles`, or 1 when `out_cycles` is 0. `in_ready` is 0 from edge k until that pulse, and `in_valid` is ignored meanwhile: no second result is produced.
- R3: A zero divisor, in either mode, gives `out_div_zero`=1, `out_overflow`=0 and `out_cycles`=0. The quotient and remainder keep their previous values.
- R4: Unsigned mode (`in_signed`=0) with dividend[31:16] ≥ divisor gives `out_overflow`=1 and `out_cycles`=6. The quotient and remainder are unchanged.
- R5: Unsigned mode without overflow gives the floor quotient and the remainder, with `out_overflow`=0.
- R6: The unsigned count is 2·s−4. The step count s starts at 38. There are then 15 iterations, each on the running 32-bit value v with h = divisor·65536. Each iteration shifts v left by one. If the bit shifted out was 1, it subtracts h from v at no cost. Otherwise it adds 2 to s, and if v ≥ h it subtracts h from v and takes 1 back off s.
- R7: In signed mode, let a and b be the magnitudes of the dividend and the divisor. If a shifted right by 16 is ≥ b, the block sets `out_overflow`=1 and leaves the quotient and remainder unchanged. The count is then 12 for a non-negative dividend and 14 for a negative one.
- R8: Otherwise the signed count is 2·s−4. The step count s is built from these parts:
  - a base of 61;
  - plus 1 if the dividend is negative;
  - if the divisor is non-negative, plus 1 more for a negative dividend, or minus 1 for a non-negative one;
  - plus the number of zero bits in bits 15..1 of the magnitude quotient a/b.
- R9: Signed results truncate toward zero. The quotient is negative when exactly one operand is negative, and the remainder has the sign of the dividend.
- R10: A signed quotient outside −32768..32767 is detected only after the full computation. It sets `out_overflow`=1, reports the R8 count, and leaves the quotient and remainder unchanged.
- R11: The quotient value −32768 is in range and is delivered with `out_overflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block idle, request will be taken |
| in_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| in_dividend | input | 32 | Dividend |
| in_divisor | input | 16 | Divisor |
| out_valid | output | 1 | One-cycle result pulse, no back-pressure |
| out_quotient | output | 16 | Quotient (held on overflow or zero divisor) |
| out_remainder | output | 16 | Remainder (held on overflow or zero divisor) |
| out_div_zero | output | 1 | Divisor was zero |
| out_overflow | output | 1 | Quotient does not fit |
| out_cycles | output | 8 | Legacy cycle count for this operation |

## Verification
The assertions check the following on every cycle:
- the one-cycle `out_valid` pulse and the drop of `in_ready` after acceptance;
- the zero-divisor and unsigned-overflow counts;
- that results are held on overflow and zero divisor;
- the bounds of the unsigned step counter and of the signed count.

Only the directed scenarios can show the rest:
- the exact per-bit counts of R6 and R8;
- the exact distance from acceptance to the pulse;
- quotient signs and truncation;
- late signed overflow against the in-range −32768 boundary;
- that requests offered while busy are dropped.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  // Legacy step constants (one step = two clock cycles)
  localparam int unsigned U_START_STEPS = 38;
  localparam int unsigned U_OVF_STEPS   = 5;
  localparam int unsigned S_START_STEPS = 6;
  localparam int unsigned S_ABS_EXTRA   = 2;
  localparam int unsigned S_BODY_STEPS  = 55;
  localparam int unsigned CYCLE_TRIM    = 4;
  localparam int unsigned MAX_S_CYCLES  = 152;
endpackage

// File: rtl/sdiv_classify.sv
module sdiv_classify
  import sdiv_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int CYC_W = 8,
  localparam int DVD_W = 2 * DIV_W
) (
  input  logic [DVD_W-1:0] dividend,
  input  logic [DIV_W-1:0] divisor,
  input  logic             is_signed,
  output logic [DVD_W-1:0] mag_dvd,
  output logic [DIV_W-1:0] mag_dvs,
  output logic             dvd_neg,
  output logic             dvs_neg,
  output logic             dvs_zero,
  output logic             early_ovf,
  output logic [CYC_W-1:0] early_cycles
);
  always_comb begin
    dvd_neg  = is_signed & dividend[DVD_W-1];
    dvs_neg  = is_signed & divisor[DIV_W-1];
    mag_dvd  = dvd_neg ? (~dividend + 1'b1) : dividend;
    mag_dvs  = dvs_neg ? (~divisor + 1'b1) : divisor;
    dvs_zero = (divisor == '0);
    early_ovf = !dvs_zero && (mag_dvd[DVD_W-1:DIV_W] >= mag_dvs);
    if (dvs_zero) begin
      early_cycles = '0;
    end else if (!is_signed) begin
      early_cycles = CYC_W'(2 * U_OVF_STEPS - CYCLE_TRIM);
    end else begin
      early_cycles = CYC_W'(2 * (S_START_STEPS + S_ABS_EXTRA) - CYCLE_TRIM)
                   + (dvd_neg ? CYC_W'(2) : CYC_W'(0));
    end
  end
endmodule

// File: rtl/sdiv_shift_engine.sv
module sdiv_shift_engine
  import sdiv_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int STEP_W = 8,
  localparam int DVD_W = 2 * DIV_W,
  localparam int IDX_W = $clog2(DIV_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DVD_W-1:0]  load_dvd,
  input  logic [DIV_W-1:0]  load_dvs,
  output logic [DVD_W-1:0]  work,
  output logic [STEP_W-1:0] steps,
  output logic              finished
);
  logic [DVD_W-1:0] hdiv;
  logic [IDX_W-1:0] idx;
  logic             running;
  logic [DVD_W-1:0] shifted;
  logic             carry, ge, take;

  always_comb begin
    carry   = work[DVD_W-1];
    shifted = {work[DVD_W-2:0], 1'b0};
    ge      = (shifted >= hdiv);
    take    = carry | ge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work     <= '0;
      hdiv     <= '0;
      idx      <= '0;
      steps    <= '0;
      running  <= 1'b0;
      finished <= 1'b0;
    end else if (load) begin
      work     <= load_dvd;
      hdiv     <= {load_dvs, {DIV_W{1'b0}}};
      idx      <= '0;
      steps    <= STEP_W'(U_START_STEPS);
      running  <= 1'b1;
      finished <= 1'b0;
    end else if (running) begin
      if (take) work <= (shifted - hdiv) | DVD_W'(1);
      else      work <= shifted;
      // only the first DIV_W-1 iterations carry a cost
      if (idx < IDX_W'(DIV_W - 1) && !carry)
        steps <= steps + (ge ? STEP_W'(1) : STEP_W'(2));
      idx <= idx + 1'b1;
      if (idx == IDX_W'(DIV_W - 1)) begin
        running  <= 1'b0;
        finished <= 1'b1;
      end
    end
  end

  // R6: the unsigned step count stays within the legacy best/worst bounds
  a_r6_step_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    finished |-> (steps >= STEP_W'(U_START_STEPS) &&
                  steps <= STEP_W'(U_START_STEPS + 2 * (DIV_W - 1))));
  // R5: completion only follows a running engine
  a_r5_finish_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(finished) |-> $past(running));
endmodule

// File: rtl/sdiv_settle.sv
module sdiv_settle
  import sdiv_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int CYC_W  = 8,
  parameter int STEP_W = 8,
  localparam int DVD_W = 2 * DIV_W
) (
  input  logic              is_signed,
  input  logic              dvd_neg,
  input  logic              dvs_neg,
  input  logic [STEP_W-1:0] u_steps,
  input  logic [DVD_W-1:0]  work,
  output logic [DIV_W-1:0]  quot,
  output logic [DIV_W-1:0]  rem,
  output logic              late_ovf,
  output logic [CYC_W-1:0]  cycles
);
  localparam logic [DIV_W-1:0] HALF = {1'b1, {(DIV_W-1){1'b0}}};

  logic [DIV_W-1:0]  mag_q, mag_r;
  logic              q_neg;
  logic [STEP_W-1:0] zeros, s_steps, fin_steps;

  always_comb begin
    mag_q = work[DIV_W-1:0];
    mag_r = work[DVD_W-1:DIV_W];
    q_neg = dvd_neg ^ dvs_neg;
    quot  = (is_signed && q_neg) ? (~mag_q + 1'b1) : mag_q;
    rem   = (is_signed && dvd_neg) ? (~mag_r + 1'b1) : mag_r;
    late_ovf = is_signed && (q_neg ? (mag_q > HALF) : (mag_q >= HALF));

    zeros = '0;
    for (int b = 1; b < DIV_W; b++) begin
      if (!mag_q[b]) zeros = zeros + STEP_W'(1);
    end
    s_steps = STEP_W'(S_START_STEPS + S_BODY_STEPS) + zeros;
    if (dvd_neg) s_steps = s_steps + STEP_W'(1);
    if (!dvs_neg) begin
      if (dvd_neg) s_steps = s_steps + STEP_W'(1);
      else         s_steps = s_steps - STEP_W'(1);
    end
    fin_steps = is_signed ? s_steps : u_steps;
    cycles    = CYC_W'({fin_steps, 1'b0}) - CYC_W'(CYCLE_TRIM);
  end
endmodule

// File: rtl/sdiv_legacy_timed.sv
module sdiv_legacy_timed
  import sdiv_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int CYC_W  = 8,
  parameter int STEP_W = 8,
  localparam int DVD_W = 2 * DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_signed,
  input  logic [DVD_W-1:0] in_dividend,
  input  logic [DIV_W-1:0] in_divisor,
  output logic             out_valid,
  output logic [DIV_W-1:0] out_quotient,
  output logic [DIV_W-1:0] out_remainder,
  output logic             out_div_zero,
  output logic             out_overflow,
  output logic [CYC_W-1:0] out_cycles
);
  logic [DVD_W-1:0]  c_mag_dvd;
  logic [DIV_W-1:0]  c_mag_dvs;
  logic              c_dvd_neg, c_dvs_neg, c_zero, c_eovf;
  logic [CYC_W-1:0]  c_ecyc;

  logic              busy, mode_q, dvd_neg_q, dvs_neg_q, zero_q, eovf_q;
  logic [CYC_W-1:0]  ecyc_q, elapsed;
  logic              accept, early_hit, finish_now;
  logic [CYC_W-1:0]  early_target;

  logic [DVD_W-1:0]  e_work;
  logic [STEP_W-1:0] e_steps;
  logic              e_finished;

  logic [DIV_W-1:0]  s_quot, s_rem;
  logic              s_late_ovf;
  logic [CYC_W-1:0]  s_cycles;

  sdiv_classify #(.DIV_W(DIV_W), .CYC_W(CYC_W)) u_classify (
    .dividend    (in_dividend),
    .divisor     (in_divisor),
    .is_signed   (in_signed),
    .mag_dvd     (c_mag_dvd),
    .mag_dvs     (c_mag_dvs),
    .dvd_neg     (c_dvd_neg),
    .dvs_neg     (c_dvs_neg),
    .dvs_zero    (c_zero),
    .early_ovf   (c_eovf),
    .early_cycles(c_ecyc)
  );

  sdiv_shift_engine #(.DIV_W(DIV_W), .STEP_W(STEP_W)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .load_dvd(c_mag_dvd),
    .load_dvs(c_mag_dvs),
    .work    (e_work),
    .steps   (e_steps),
    .finished(e_finished)
  );

  sdiv_settle #(.DIV_W(DIV_W), .CYC_W(CYC_W), .STEP_W(STEP_W)) u_settle (
    .is_signed(mode_q),
    .dvd_neg  (dvd_neg_q),
    .dvs_neg  (dvs_neg_q),
    .u_steps  (e_steps),
    .work     (e_work),
    .quot     (s_quot),
    .rem      (s_rem),
    .late_ovf (s_late_ovf),
    .cycles   (s_cycles)
  );

  always_comb begin
    in_ready     = !busy;
    accept       = in_valid && !busy;
    early_hit    = zero_q || eovf_q;
    early_target = zero_q ? CYC_W'(1) : ecyc_q;
    finish_now   = busy && (early_hit ? (elapsed == early_target)
                                      : (e_finished && elapsed == s_cycles));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy          <= 1'b0;
      mode_q        <= 1'b0;
      dvd_neg_q     <= 1'b0;
      dvs_neg_q     <= 1'b0;
      zero_q        <= 1'b0;
      eovf_q        <= 1'b0;
      ecyc_q        <= '0;
      elapsed       <= '0;
      out_valid     <= 1'b0;
      out_quotient  <= '0;
      out_remainder <= '0;
      out_div_zero  <= 1'b0;
      out_overflow  <= 1'b0;
      out_cycles    <= '0;
    end else begin
      out_valid <= 1'b0;
      if (accept) begin
        busy      <= 1'b1;
        elapsed   <= CYC_W'(1);
        mode_q    <= in_signed;
        dvd_neg_q <= c_dvd_neg;
        dvs_neg_q <= c_dvs_neg;
        zero_q    <= c_zero;
        eovf_q    <= c_eovf;
        ecyc_q    <= c_ecyc;
      end else if (busy) begin
        if (finish_now) begin
          busy         <= 1'b0;
          out_valid    <= 1'b1;
          out_div_zero <= zero_q;
          out_overflow <= eovf_q || (!early_hit && s_late_ovf);
          out_cycles   <= early_hit ? ecyc_q : s_cycles;
          if (!early_hit && !s_late_ovf) begin
            out_quotient  <= s_quot;
            out_remainder <= s_rem;
          end
        end else begin
          elapsed <= elapsed + CYC_W'(1);
        end
      end
    end
  end

  // R2: the result is a single-cycle pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R2: acceptance closes the input side
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  // R3: zero divisor reports zero cycles and no overflow
  a_r3_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_div_zero) |-> (out_cycles == '0 && !out_overflow));
  // R4: unsigned overflow costs six cycles
  a_r4_unsigned_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overflow && !mode_q) |-> (out_cycles == CYC_W'(6)));
  // R10: no result update on overflow or zero divisor
  a_r10_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_overflow || out_div_zero)) |->
      ($stable(out_quotient) && $stable(out_remainder)));
  // R8: signed counts never exceed the legacy worst case
  a_r8_signed_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_q) |-> (out_cycles <= CYC_W'(MAX_S_CYCLES)));
endmodule

// File: tb/test_sdiv_legacy_timed.sv
module test_sdiv_legacy_timed;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_signed = 1'b0;
  logic [31:0] in_dividend = '0;
  logic [15:0] in_divisor = '0;
  logic        out_valid;
  logic [15:0] out_quotient, out_remainder;
  logic        out_div_zero, out_overflow;
  logic [7:0]  out_cycles;

  int checks = 0;
  int failures = 0;
  logic [15:0] held_q = '0;
  logic [15:0] held_r = '0;

  always #10 clk = ~clk;

  sdiv_legacy_timed i_sdiv_legacy_timed (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_signed(in_signed), .in_dividend(in_dividend), .in_divisor(in_divisor),
    .out_valid(out_valid), .out_quotient(out_quotient), .out_remainder(out_remainder),
    .out_div_zero(out_div_zero), .out_overflow(out_overflow), .out_cycles(out_cycles)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model_ucycles(input logic [31:0] a, input logic [15:0] b);
    int s = 38;
    logic [31:0] v = a;
    logic [31:0] h = {b, 16'h0};
    for (int i = 0; i < 15; i++) begin
      logic top = v[31];
      v = v << 1;
      if (top) v = v - h;
      else begin
        s = s + 2;
        if (v >= h) begin v = v - h; s = s - 1; end
      end
    end
    return 2 * s - 4;
  endfunction

  function automatic int model_scycles(input logic [31:0] a, input logic [15:0] b,
                                       output bit absovf);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint ma = (sa < 0) ? -sa : sa;
    longint mb = (sb < 0) ? -sb : sb;
    longint aq;
    int s = 6 + ((sa < 0) ? 1 : 0);
    absovf = ((ma >> 16) >= mb);
    if (absovf) return (s + 2) * 2 - 4;
    aq = ma / mb;
    s = s + 55;
    if (sb >= 0) s = s + ((sa < 0) ? 1 : -1);
    for (int i = 15; i >= 1; i--) if (aq[i] == 1'b0) s = s + 1;
    return 2 * s - 4;
  endfunction

  // drive one request and check every output against the model
  task automatic run_div(input bit sg, input logic [31:0] a, input logic [15:0] b,
                         input string creq, input string rreq);
    int n = 0;
    int exp_cyc;
    bit exp_dz, exp_ovf, absovf;
    longint q, r;
    @(negedge clk);
    chk(in_ready == 1'b1, "R2", "idle ready", in_ready, 1);
    in_valid = 1'b1; in_signed = sg; in_dividend = a; in_divisor = b;
    @(posedge clk);
    #1 in_valid = 1'b0;
    do begin
      @(posedge clk); n++; @(negedge clk);
    end while (!out_valid && n < 400);
    exp_dz = (b == 16'h0);
    exp_ovf = 1'b0;
    if (exp_dz) exp_cyc = 0;
    else if (!sg) begin
      q = longint'(a) / longint'(b);
      r = longint'(a) % longint'(b);
      exp_ovf = (a[31:16] >= b);
      exp_cyc = exp_ovf ? 6 : model_ucycles(a, b);
    end else begin
      exp_cyc = model_scycles(a, b, absovf);
      q = longint'($signed(a)) / longint'($signed(b));
      r = longint'($signed(a)) % longint'($signed(b));
      exp_ovf = absovf || q > 32767 || q < -32768;
    end
    if (!exp_dz && !exp_ovf) begin held_q = q[15:0]; held_r = r[15:0]; end
    chk(out_valid == 1'b1, "R2", "result pulse seen", out_valid, 1);
    chk(n == ((exp_cyc == 0) ? 1 : exp_cyc), "R2", "latency", n, (exp_cyc == 0) ? 1 : exp_cyc);
    chk(out_cycles == exp_cyc[7:0], creq, "cycle count", out_cycles, exp_cyc);
    chk(out_div_zero == exp_dz, "R3", "div zero flag", out_div_zero, exp_dz);
    chk(out_overflow == exp_ovf, rreq, "overflow flag", out_overflow, exp_ovf);
    chk(out_quotient == held_q, rreq, "quotient", out_quotient, held_q);
    chk(out_remainder == held_r, rreq, "remainder", out_remainder, held_r);
    @(negedge clk);
    chk(out_valid == 1'b0, "R2", "pulse one cycle", out_valid, 0);
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R1", "reset ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "reset valid", out_valid, 0);
    chk(out_quotient == 16'h0 && out_remainder == 16'h0, "R1", "reset results",
        {out_quotient, out_remainder}, 0);
    chk(out_cycles == 8'h0 && !out_overflow && !out_div_zero, "R1", "reset flags",
        out_cycles, 0);
  endtask

  task automatic t_unsigned();
    run_div(1'b0, 32'd100, 16'd7, "R6", "R5");
    run_div(1'b0, 32'h0, 16'd1, "R6", "R5");
    run_div(1'b0, 32'h1234_5678, 16'hFFFF, "R6", "R5");
    run_div(1'b0, 32'h0004_FFFF, 16'd5, "R6", "R5");
  endtask

  task automatic t_unsigned_overflow();
    run_div(1'b0, 32'h0005_0000, 16'd5, "R4", "R4");
    run_div(1'b0, 32'hFFFF_FFFF, 16'd3, "R4", "R4");
  endtask

  task automatic t_zero();
    run_div(1'b0, 32'd1234, 16'd0, "R3", "R3");
    run_div(1'b1, 32'hFFFF_FF00, 16'd0, "R3", "R3");
  endtask

  task automatic t_signed();
    run_div(1'b1, 32'd100, 16'd7, "R8", "R9");
    run_div(1'b1, -32'sd100, 16'd7, "R8", "R9");
    run_div(1'b1, 32'd100, -16'sd7, "R8", "R9");
    run_div(1'b1, -32'sd100, -16'sd7, "R8", "R9");
    run_div(1'b1, 32'd32767, 16'd1, "R8", "R9");
  endtask

  task automatic t_signed_abs_overflow();
    run_div(1'b1, -32'sd65536, 16'd1, "R7", "R7");
    run_div(1'b1, 32'h7FFF_0000, 16'h7FFF, "R7", "R7");
  endtask

  task automatic t_signed_late_overflow();
    run_div(1'b1, 32'd32768, 16'd1, "R8", "R10");
    run_div(1'b1, -32'sd65535, -16'sd1, "R8", "R10");
    run_div(1'b1, -32'sd32768, 16'd1, "R8", "R11");
    run_div(1'b1, 32'd32768, -16'sd1, "R8", "R11");
  endtask

  task automatic t_busy_ignore();
    int n = 0;
    int exp_cyc = model_ucycles(32'd0, 16'd1);
    @(negedge clk);
    in_valid = 1'b1; in_signed = 1'b0; in_dividend = 32'd0; in_divisor = 16'd1;
    @(posedge clk);
    #1 in_dividend = 32'd999; in_divisor = 16'd2;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); n++; @(negedge clk);
      chk(in_ready == 1'b0, "R2", "busy ready low", in_ready, 0);
    end
    in_valid = 1'b0;
    do begin
      @(posedge clk); n++; @(negedge clk);
    end while (!out_valid && n < 400);
    held_q = 16'h0; held_r = 16'h0;
    chk(n == exp_cyc, "R2", "busy latency", n, exp_cyc);
    chk(out_quotient == 16'h0 && out_remainder == 16'h0, "R2", "busy input ignored",
        out_quotient, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R2", "no second result", out_valid, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unsigned();
    t_unsigned_overflow();
    t_zero();
    t_signed();
    t_signed_abs_overflow();
    t_signed_late_overflow();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule